// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address. It walks a page table with three levels that is kept in memory. A request carries the virtual address, the privilege mode of the requester (user or kernel), whether the access is a write, and the physical base of the first-level table. The walker first checks that the address is properly sign-extended from its 43 implemented bits. It then reads one 8-byte entry per level through a single memory read port. That port uses a valid/ready request and returns its response after a variable number of cycles.

Every entry must be valid. The last-level entry must also grant the permission that the requester's mode and access type need. The walker returns one of two results. On success it returns the physical address, made from the final frame number and the 13-bit page offset. On failure it returns a fault code and the level at which the walk stopped. Each response also carries a segment class taken from the top two address bits. Only one walk is in progress at a time. There is no caching of entries.

Top module: `pt_walker`

## Requirements
- R1: While reset is active and after it, req_ready_o is 1 and mem_req_valid_o and rsp_valid_o are 0.
- R2: If bits 63:42 of the virtual address are not all equal, the response has fault 1, level 0 and paddr 0, and no memory read is issued.
- R3: rsp_seg_o is 0 when bit 63 is 0, 1 when bits 63:62 are 11, and 2 when bits 63:62 are 10. This holds on every response, including faulting ones.
- R4: The first read goes to ptbr_i + va[42:33]*8.
- R5: Each later read goes to (previous entry[63:32] << 13) + index*8. The index is va[32:23] for the second level and va[22:13] for the third.
- R6: An entry whose bit 0 (valid) is 0 ends the walk with fault 2 and the level of that entry (1, 2 or 3). No further reads are issued.
- R7: Only the third-level entry is checked for permission. The bit needed is bit 1 for a kernel read, bit 2 for a user read, bit 3 for a kernel write and bit 4 for a user write. If that bit is 0, the response has fault 3, level 3 and paddr 0. Entries at the upper levels need only the valid bit.
- R8: A successful walk responds with fault 0, level 3 and paddr = {entry[63:32], va[12:0]}, zero-extended.
- R9: req_ready_o is 0 from the cycle after a request is accepted up to and including the cycle of rsp_valid_o. Requests offered in that time are ignored.
- R10: mem_req_valid_o holds its address steady until mem_req_ready_i is seen. At most one read is outstanding, and none is issued while the walker is idle.
- R11: rsp_valid_o is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request present |
| req_ready_o | output | 1 | Walker idle and able to accept |
| req_vaddr_i | input | 64 | Virtual address to translate |
| req_user_i | input | 1 | 1 = user mode, 0 = kernel mode |
| req_write_i | input | 1 | 1 = write access, 0 = read access |
| ptbr_i | input | 64 | Physical base of the first-level table (page aligned) |
| mem_req_valid_o | output | 1 | Entry read request |
| mem_req_ready_i | input | 1 | Memory accepts the read |
| mem_req_addr_o | output | 64 | Physical address of the 8-byte entry |
| mem_rsp_valid_i | input | 1 | Read data returned |
| mem_rsp_data_i | input | 64 | Entry contents |
| rsp_valid_o | output | 1 | Result pulse |
| rsp_paddr_o | output | 64 | Physical address (0 on fault) |
| rsp_fault_o | output | 2 | 0 none, 1 bad sign extension, 2 invalid entry, 3 protection |
| rsp_level_o | output | 2 | Level of the last entry read (0 if none) |
| rsp_seg_o | output | 2 | Segment class of the virtual address |

## Verification
Two events can fall in the same cycle: a result being delivered and a new request being offered. The bench provokes this by holding req_valid_i high with a malformed address throughout every busy cycle, including the one in which rsp_valid_o pulses. The reference model then expects req_ready_o low in that cycle, no extra read and no extra result. The next real request must be accepted only after ready has returned. Memory acceptance and response latency are drawn at random, so entry reads and their data also arrive against different walker states. The issued addresses, results and segment classes are compared with a behavioural walk over the bench's own table image.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_SIGN    = 2'd1,
    FLT_INVALID = 2'd2,
    FLT_PROT    = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    SEG_UCODE  = 2'd0,
    SEG_USTACK = 2'd1,
    SEG_KERNEL = 2'd2,
    SEG_RSVD   = 2'd3
  } seg_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHK,
    ST_SEND,
    ST_WAIT,
    ST_DONE
  } walk_state_e;

endpackage

// File: rtl/pt_va_decode.sv
module pt_va_decode
  import pt_walker_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int VA_BITS   = 43,
  parameter int IDX_BITS  = 10,
  parameter int LEVELS    = 3
) (
  input  logic [ADDR_W-1:0]                va_i,
  output logic                             sign_ok_o,
  output seg_e                             seg_o,
  output logic [LEVELS-1:0][IDX_BITS-1:0]  idx_o
);
  localparam int HI_W = ADDR_W - VA_BITS + 1;

  logic [HI_W-1:0] hi;
  assign hi        = va_i[ADDR_W-1 -: HI_W];
  assign sign_ok_o = (&hi) | ~(|hi);

  always_comb begin
    if (!va_i[ADDR_W-1])      seg_o = SEG_UCODE;
    else if (va_i[ADDR_W-2])  seg_o = SEG_USTACK;
    else                      seg_o = SEG_KERNEL;
  end

  // level 1 takes the highest index field
  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idx_o[g] = va_i[VA_BITS-1 - g*IDX_BITS -: IDX_BITS];
  end

endmodule

// File: rtl/pt_perm_check.sv
module pt_perm_check (
  input  logic [3:0] flags_i,   // {user wr, kernel wr, user rd, kernel rd}
  input  logic       user_i,
  input  logic       write_i,
  output logic       allow_o
);
  assign allow_o = flags_i[{write_i, user_i}];
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int VA_BITS   = 43,
  parameter int PAGE_BITS = 13,
  parameter int IDX_BITS  = 10,
  parameter int LEVELS    = 3,
  parameter int PFN_LSB   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_vaddr_i,
  input  logic              req_user_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] ptbr_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [ADDR_W-1:0] mem_rsp_data_i,
  output logic              rsp_valid_o,
  output logic [ADDR_W-1:0] rsp_paddr_o,
  output logic [1:0]        rsp_fault_o,
  output logic [1:0]        rsp_level_o,
  output logic [1:0]        rsp_seg_o
);
  localparam int LVL_W     = $clog2(LEVELS + 1);
  localparam int PTE_SHIFT = 3;
  localparam int PFN_W     = ADDR_W - PFN_LSB;

  walk_state_e state_q;
  logic [ADDR_W-1:0] va_q, base_q, paddr_q;
  logic              user_q, write_q;
  logic [LVL_W-1:0]  lvl_q, flt_lvl_q;
  fault_e            fault_q;

  logic                            sign_ok;
  seg_e                            seg;
  logic [LEVELS-1:0][IDX_BITS-1:0] idx;
  logic                            allow;
  logic [PFN_W-1:0]                pfn;
  logic [ADDR_W-1:0]               frame_base;
  logic                            last_lvl;

  pt_va_decode #(
    .ADDR_W(ADDR_W), .VA_BITS(VA_BITS), .IDX_BITS(IDX_BITS), .LEVELS(LEVELS)
  ) u_decode (
    .va_i(va_q), .sign_ok_o(sign_ok), .seg_o(seg), .idx_o(idx)
  );

  pt_perm_check u_perm (
    .flags_i(mem_rsp_data_i[4:1]),
    .user_i (user_q),
    .write_i(write_q),
    .allow_o(allow)
  );

  assign pfn        = mem_rsp_data_i[ADDR_W-1:PFN_LSB];
  assign frame_base = ADDR_W'(pfn) << PAGE_BITS;
  assign last_lvl   = (lvl_q == LVL_W'(LEVELS - 1));

  assign req_ready_o     = (state_q == ST_IDLE);
  assign mem_req_valid_o = (state_q == ST_SEND);
  assign mem_req_addr_o  = base_q + (ADDR_W'(idx[lvl_q]) << PTE_SHIFT);
  assign rsp_valid_o     = (state_q == ST_DONE);
  assign rsp_paddr_o     = paddr_q;
  assign rsp_fault_o     = fault_q;
  assign rsp_level_o     = flt_lvl_q;
  assign rsp_seg_o       = seg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      va_q      <= '0;
      base_q    <= '0;
      paddr_q   <= '0;
      user_q    <= 1'b0;
      write_q   <= 1'b0;
      lvl_q     <= '0;
      flt_lvl_q <= '0;
      fault_q   <= FLT_NONE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          va_q      <= req_vaddr_i;
          user_q    <= req_user_i;
          write_q   <= req_write_i;
          base_q    <= ptbr_i;
          lvl_q     <= '0;
          flt_lvl_q <= '0;
          paddr_q   <= '0;
          fault_q   <= FLT_NONE;
          state_q   <= ST_CHK;
        end
        ST_CHK: begin
          if (sign_ok) state_q <= ST_SEND;
          else begin
            fault_q <= FLT_SIGN;
            state_q <= ST_DONE;
          end
        end
        ST_SEND: if (mem_req_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid_i) begin
          if (!mem_rsp_data_i[0]) begin
            fault_q   <= FLT_INVALID;
            flt_lvl_q <= lvl_q + 1'b1;
            state_q   <= ST_DONE;
          end else if (!last_lvl) begin
            base_q  <= frame_base;
            lvl_q   <= lvl_q + 1'b1;
            state_q <= ST_SEND;
          end else begin
            flt_lvl_q <= LVL_W'(LEVELS);
            state_q   <= ST_DONE;
            if (allow) paddr_q <= frame_base | ADDR_W'(va_q[PAGE_BITS-1:0]);
            else       fault_q <= FLT_PROT;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int ADDR_W = 64,
  parameter int LEVELS = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              mem_req_valid_o,
  input logic              mem_req_ready_i,
  input logic [ADDR_W-1:0] mem_req_addr_o,
  input logic              rsp_valid_o,
  input logic [1:0]        rsp_fault_o,
  input logic [1:0]        rsp_level_o
);
  // R9
  busy_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o);

  // R10
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

  // R10
  idle_mem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_valid_o);

  // R11
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  // R2
  sign_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o == 2'd1) |-> (rsp_level_o == 2'd0));

  // R7
  prot_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o == 2'd3) |-> (rsp_level_o == 2'(LEVELS)));

  // R8
  ok_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o == 2'd0) |-> (rsp_level_o == 2'(LEVELS)));

endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W), .LEVELS(LEVELS)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_ready_o    (req_ready_o),
  .mem_req_valid_o(mem_req_valid_o),
  .mem_req_ready_i(mem_req_ready_i),
  .mem_req_addr_o (mem_req_addr_o),
  .rsp_valid_o    (rsp_valid_o),
  .rsp_fault_o    (rsp_fault_o),
  .rsp_level_o    (rsp_level_o)
);

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;
  localparam logic [63:0] PTBR = 64'h0000_0000_0001_0000;
  localparam logic [63:0] JUNK = 64'h0000_0800_0000_0000;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        req_valid_i, req_ready_o, req_user_i, req_write_i;
  logic [63:0] req_vaddr_i, ptbr_i;
  logic        mem_req_valid_o, mem_req_ready_i, mem_rsp_valid_i;
  logic [63:0] mem_req_addr_o, mem_rsp_data_i;
  logic        rsp_valid_o;
  logic [63:0] rsp_paddr_o;
  logic [1:0]  rsp_fault_o, rsp_level_o, rsp_seg_o;

  pt_walker u_pt_walker (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_vaddr_i(req_vaddr_i), .req_user_i(req_user_i), .req_write_i(req_write_i),
    .ptbr_i(ptbr_i),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
    .mem_req_addr_o(mem_req_addr_o),
    .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_data_i(mem_rsp_data_i),
    .rsp_valid_o(rsp_valid_o), .rsp_paddr_o(rsp_paddr_o),
    .rsp_fault_o(rsp_fault_o), .rsp_level_o(rsp_level_o), .rsp_seg_o(rsp_seg_o)
  );

  initial forever #5 clk_i = ~clk_i;

  int checks = 0;
  int errors = 0;

  logic [63:0] pmem [logic [63:0]];
  logic [63:0] st_va[$];
  bit          st_user[$];
  bit          st_wr[$];
  logic [63:0] exp_addr_q[$];
  logic [63:0] exp_paddr;
  int          exp_fault, exp_level, exp_seg;
  bit          in_walk = 0;
  int          addr_lvl = 0;
  bit          busy = 0;
  int          lat = 0;
  logic [63:0] cap_addr;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mkva(bit neg, int i1, int i2, int i3, int off);
    logic [63:0] v;
    v = neg ? 64'hFFFF_F800_0000_0000 : 64'h0;
    v = v | (64'(i1) << 33) | (64'(i2) << 23) | (64'(i3) << 13) | 64'(off);
    return v;
  endfunction

  function automatic logic [63:0] pte(int pfn, int flags);
    return (64'(pfn) << 32) | 64'(flags);
  endfunction

  task automatic add_req(logic [63:0] va, bit user, bit wr);
    st_va.push_back(va); st_user.push_back(user); st_wr.push_back(wr);
  endtask

  // behavioural walk over the bench's table image
  task automatic ref_walk(input logic [63:0] va, input bit user, input bit wr);
    logic [63:0] base, a, e, idx;
    int bitn;
    exp_seg   = !va[63] ? 0 : (va[62] ? 1 : 2);
    exp_paddr = 64'h0;
    exp_level = 0;
    exp_fault = 0;
    if (!(va[63:42] == '1 || va[63:42] == '0)) begin
      exp_fault = 1;
      return;
    end
    base = PTBR;
    for (int l = 0; l < 3; l++) begin
      idx = (va >> (33 - 10*l)) & 64'h3FF;
      a = base + idx * 8;
      exp_addr_q.push_back(a);
      e = pmem.exists(a) ? pmem[a] : 64'h0;
      if (!e[0]) begin
        exp_fault = 2; exp_level = l + 1;
        return;
      end
      if (l < 2) base = {32'h0, e[63:32]} * 64'd8192;
      else begin
        exp_level = 3;
        bitn = wr ? (user ? 4 : 3) : (user ? 2 : 1);
        if (!e[bitn]) exp_fault = 3;
        else exp_paddr = ({32'h0, e[63:32]} << 13) | {51'h0, va[12:0]};
      end
    end
  endtask

  task automatic driver_loop();
    string tag;
    forever begin
      @(negedge clk_i);
      // memory response
      mem_rsp_valid_i = 1'b0;
      if (busy) begin
        if (lat == 0) begin
          mem_rsp_valid_i = 1'b1;
          mem_rsp_data_i  = pmem.exists(cap_addr) ? pmem[cap_addr] : 64'h0;
          busy = 0;
        end else lat--;
      end
      // per-cycle comparison
      chk(req_ready_o == !in_walk, "R9", "req_ready_o", 64'(req_ready_o), 64'(!in_walk));
      if (mem_req_valid_o) begin
        if (exp_addr_q.size() == 0)
          chk(1'b0, "R10", "unexpected read", mem_req_addr_o, 64'h0);
        else
          chk(mem_req_addr_o == exp_addr_q[0], (addr_lvl == 0) ? "R4" : "R5",
              "entry address", mem_req_addr_o, exp_addr_q[0]);
      end
      if (rsp_valid_o) begin
        if (!in_walk) chk(1'b0, "R11", "extra response", 64'(rsp_valid_o), 64'h0);
        else begin
          tag = (exp_fault == 1) ? "R2" : (exp_fault == 2) ? "R6" :
                (exp_fault == 3) ? "R7" : "R8";
          chk(rsp_fault_o == 2'(exp_fault), tag, "fault", 64'(rsp_fault_o), 64'(exp_fault));
          chk(rsp_level_o == 2'(exp_level), tag, "level", 64'(rsp_level_o), 64'(exp_level));
          chk(rsp_paddr_o == exp_paddr, tag, "paddr", rsp_paddr_o, exp_paddr);
          chk(rsp_seg_o == 2'(exp_seg), "R3", "segment", 64'(rsp_seg_o), 64'(exp_seg));
          chk(exp_addr_q.size() == 0, "R6", "reads left", 64'(exp_addr_q.size()), 64'h0);
          exp_addr_q.delete();
          in_walk = 0;
        end
      end
      // memory acceptance
      mem_req_ready_i = 1'b0;
      if (!busy && mem_req_valid_o) begin
        mem_req_ready_i = 1'($urandom_range(0, 1));
        if (mem_req_ready_i) begin
          busy = 1;
          lat = $urandom_range(0, 3);
          cap_addr = mem_req_addr_o;
          if (exp_addr_q.size() > 0) void'(exp_addr_q.pop_front());
          addr_lvl++;
        end
      end
      // requests; junk is offered whenever the walker is busy
      if (!in_walk && req_ready_o && st_va.size() > 0) begin
        req_valid_i = 1'b1;
        req_vaddr_i = st_va.pop_front();
        req_user_i  = st_user.pop_front();
        req_write_i = st_wr.pop_front();
        ref_walk(req_vaddr_i, req_user_i, req_write_i);
        in_walk  = 1;
        addr_lvl = 0;
      end else if (!req_ready_o) begin
        req_valid_i = 1'b1;
        req_vaddr_i = JUNK;
        req_user_i  = 1'b1;
        req_write_i = 1'b1;
      end else req_valid_i = 1'b0;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    req_valid_i = 0; req_vaddr_i = 0; req_user_i = 0; req_write_i = 0;
    ptbr_i = PTBR;
    mem_req_ready_i = 0; mem_rsp_valid_i = 0; mem_rsp_data_i = 0;

    // table image; upper levels carry only the valid bit
    pmem[PTBR + 64'd1 * 8]       = pte(32'h20, 5'h01);
    pmem[PTBR + 64'd1023 * 8]    = pte(32'h20, 5'h01);
    pmem[64'h40000 + 64'd2 * 8]  = pte(32'h30, 5'h01);
    pmem[64'h40000 + 64'd7 * 8]  = pte(32'h31, 5'h1E);
    pmem[64'h60000 + 64'd3 * 8]  = pte(32'hABCDE, 5'h1F);
    pmem[64'h60000 + 64'd4 * 8]  = pte(32'h111, 5'h03);
    pmem[64'h60000 + 64'd5 * 8]  = pte(32'h222, 5'h05);
    pmem[64'h60000 + 64'd6 * 8]  = pte(32'h444, 5'h1E);
    pmem[64'h60000 + 64'd8 * 8]  = pte(32'h333, 5'h19);

    for (int r = 0; r < 2; r++) begin
      add_req(mkva(0, 1, 2, 3, 13'h123), 1, 0);   // R8
      add_req(mkva(0, 1, 2, 3, 13'h000), 1, 1);   // R8
      add_req(mkva(1, 1023, 2, 3, 13'h1FFF), 1, 0); // R3 stack, R8
      add_req(mkva(0, 1, 2, 4, 13'h010), 1, 0);   // R7 user read denied
      add_req(mkva(0, 1, 2, 4, 13'h010), 0, 0);   // R7 kernel read allowed
      add_req(mkva(0, 1, 2, 4, 13'h010), 0, 1);   // R7 kernel write denied
      add_req(mkva(0, 1, 2, 5, 13'h020), 1, 0);   // R7 user read allowed
      add_req(mkva(0, 1, 2, 5, 13'h020), 1, 1);   // R7 user write denied
      add_req(mkva(0, 1, 2, 5, 13'h020), 0, 0);   // R7 kernel read denied
      add_req(mkva(0, 1, 2, 8, 13'h030), 1, 1);   // R7 user write allowed
      add_req(mkva(0, 1, 2, 8, 13'h030), 1, 0);   // R7 user read denied
      add_req(mkva(0, 1, 2, 8, 13'h030), 0, 1);   // R7 kernel write allowed
      add_req(mkva(0, 1, 2, 6, 13'h000), 0, 0);   // R6 level 3
      add_req(mkva(0, 1, 7, 0, 13'h000), 0, 0);   // R6 level 2
      add_req(mkva(0, 9, 0, 0, 13'h000), 0, 0);   // R6 level 1
      add_req(64'h0000_0400_0000_0000, 0, 0);     // R2 bit 42 alone
      add_req(64'h8000_0000_0000_0000, 0, 0);     // R2, R3 kernel class
      add_req(64'h0000_0800_0000_0000, 1, 0);     // R2
      add_req(64'hFFFF_F800_0000_0000, 1, 0);     // R2, R3 stack class
    end

    repeat (3) @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R1", "ready in reset", 64'(req_ready_o), 64'h1);
    chk(mem_req_valid_o == 1'b0, "R1", "mem valid in reset", 64'(mem_req_valid_o), 64'h0);
    chk(rsp_valid_o == 1'b0, "R1", "rsp valid in reset", 64'(rsp_valid_o), 64'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o == 1'b1 && !mem_req_valid_o && !rsp_valid_o, "R1",
        "idle after reset", {61'h0, req_ready_o, mem_req_valid_o, rsp_valid_o}, 64'h4);

    fork driver_loop(); join_none

    while (st_va.size() > 0 || in_walk) @(negedge clk_i);
    repeat (5) @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule